// File: doc/BRIEF.md
# VLAN Table Command Engine

This block keeps a small table of VLAN entries and serves it through a handful of 16-bit host registers. Each entry carries a 13-bit VLAN identifier, a valid flag, an 8-bit filtering database number and a 2-bit membership code for every port. The host puts an entry into the staging registers, then writes the operation register with the busy bit and an opcode. The engine runs the operation and drops busy when it is done.

Three operations exist. Load/purge inserts, overwrites or removes one entry. Get-next searches for the next higher valid identifier and returns the entry it finds in the staging registers, so that repeated commands walk the whole table in ascending order. Flush-all empties the table. Every operation makes one pass over all table slots, one slot per clock. Busy therefore stays high for exactly DEPTH cycles whatever the opcode, and host writes made while busy is high are dropped.

Top module: `vlan_cmd_engine`

## Requirements
- R1: A write to register 0 with bit 15 set starts a command. Bit 15 of register 0 then reads 1 for exactly DEPTH clock cycles and reads 0 afterwards.
- R2: While a command is running, host writes to any register are ignored, including a second command write. The command result is the same as if those writes had not happened.
- R3: Get-next (opcode 4) finds the valid entry with the lowest identifier strictly greater than the staged identifier. It writes that entry into the staging registers with valid set. Issuing get-next again without restaging continues the walk in ascending order.
- R4: When get-next finds no higher valid entry, it returns identifier 8191 with valid clear, so register 1 reads 0x2FFF.
- R5: Load/purge (opcode 3) with staged valid set writes the staged entry into the table. An entry that already has the same identifier is overwritten in place.
- R6: Load/purge with staged valid clear removes the entry with the staged identifier. If no entry has that identifier, the table is left as it was.
- R7: A load of a new identifier into a full table leaves the table unchanged and sets bit 4 of register 0. Bit 4 is cleared again when the next command starts.
- R8: Flush-all (opcode 1) invalidates every entry, and afterwards the table accepts new loads.
- R9: The register map is as follows.
  - Register 0 holds busy in bit 15 and the opcode in bits 14:12. It also holds the database number, with bits 7:4 of the number in bits 11:8 and bits 3:0 of the number in bits 3:0.
  - Register 1 holds identifier bits 11:0 in bits 11:0, valid in bit 12 and identifier bit 12 in bit 13.
  - Register 2+i/4 holds the membership code of port i at bits (i%4)*4+1:(i%4)*4.
- R10: After reset all registers read 0 and the table is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host register write strobe |
| host_addr | input | ADDR_W | Host register address |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Read data of the addressed register (combinational) |

## Verification
The bench fills the table to its exact depth with identifiers that are spread on both sides of the page bit, including 8191. A wrong comparison width or a lost page bit would make the walk skip entries or return them out of order. The bench then walks from several start points and counts the busy cycles of every command. A search that is not strict would return the same entry again and again. A scan that ends one slot early would miss the last slot, and so would the final slot compare.

A load of a new identifier into the full table must raise the full bit and leave the walk unchanged. An overwrite of a present identifier, made while the table is full, must succeed and must not raise the bit. Purges of present and absent identifiers, a flush, and register writes made during a running get-next show whether the engine drops stray writes and leaves the table correct.

// File: rtl/vlan_cmd_pkg.sv
package vlan_cmd_pkg;
   localparam int VID_W         = 13;
   localparam int DB_W          = 8;
   localparam int REG_W         = 16;
   localparam int PORTS_PER_REG = 4;
   localparam int CODE_W        = 2;
   localparam int CODE_STRIDE   = 4;

   localparam int REG_OP    = 0;
   localparam int REG_VID   = 1;
   localparam int REG_DATA0 = 2;

   localparam int OP_BUSY   = 15;
   localparam int OP_FULL   = 4;
   localparam int VID_VALID = 12;
   localparam int VID_PAGE  = 13;

   typedef enum logic [2:0] {
      OPC_NOP   = 3'd0,
      OPC_FLUSH = 3'd1,
      OPC_LOAD  = 3'd3,
      OPC_NEXT  = 3'd4
   } opc_e;
endpackage

// File: rtl/vlan_cmd_regs.sv
module vlan_cmd_regs
   import vlan_cmd_pkg::*;
#(
   parameter int NPORTS = 8,
   parameter int ADDR_W = 4,
   localparam int MEM_W = CODE_W * NPORTS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_we,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [REG_W-1:0]  host_wdata,
   output logic [REG_W-1:0]  host_rdata,
   output logic              cmd_start,
   output logic              busy,
   output opc_e              opcode,
   output logic [VID_W-1:0]  stg_vid,
   output logic              stg_valid,
   output logic [DB_W-1:0]   stg_db,
   output logic [MEM_W-1:0]  stg_mem,
   output logic              full,
   input  logic              eng_done,
   input  logic              full_set,
   input  logic              wb_en,
   input  logic [VID_W-1:0]  wb_vid,
   input  logic              wb_valid,
   input  logic [DB_W-1:0]   wb_db,
   input  logic [MEM_W-1:0]  wb_mem
);
   logic accept;
   logic unused_bits;

   assign accept      = host_we && !busy;
   assign cmd_start   = accept && (host_addr == ADDR_W'(REG_OP)) && host_wdata[OP_BUSY];
   assign unused_bits = ^host_wdata[7:6];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy      <= 1'b0;
         opcode    <= OPC_NOP;
         stg_vid   <= '0;
         stg_valid <= 1'b0;
         stg_db    <= '0;
         stg_mem   <= '0;
         full      <= 1'b0;
      end else begin
         if (accept) begin
            if (host_addr == ADDR_W'(REG_OP)) begin
               busy   <= host_wdata[OP_BUSY];
               opcode <= opc_e'(host_wdata[14:12]);
               stg_db <= {host_wdata[11:8], host_wdata[3:0]};
               if (host_wdata[OP_BUSY]) full <= 1'b0;
            end
            if (host_addr == ADDR_W'(REG_VID)) begin
               stg_vid   <= {host_wdata[VID_PAGE], host_wdata[11:0]};
               stg_valid <= host_wdata[VID_VALID];
            end
            for (int p = 0; p < NPORTS; p++) begin
               if (host_addr == ADDR_W'(REG_DATA0 + p / PORTS_PER_REG))
                  stg_mem[CODE_W*p +: CODE_W] <=
                     host_wdata[(p % PORTS_PER_REG)*CODE_STRIDE +: CODE_W];
            end
         end
         if (eng_done) begin
            busy <= 1'b0;
            if (full_set) full <= 1'b1;
            if (wb_en) begin
               stg_vid   <= wb_vid;
               stg_valid <= wb_valid;
               stg_db    <= wb_db;
               stg_mem   <= wb_mem;
            end
         end
      end
   end

   always_comb begin
      host_rdata = '0;
      if (host_addr == ADDR_W'(REG_OP)) begin
         host_rdata[OP_BUSY] = busy;
         host_rdata[14:12]   = opcode;
         host_rdata[11:8]    = stg_db[7:4];
         host_rdata[OP_FULL] = full;
         host_rdata[3:0]     = stg_db[3:0];
      end
      if (host_addr == ADDR_W'(REG_VID)) begin
         host_rdata[11:0]      = stg_vid[11:0];
         host_rdata[VID_VALID] = stg_valid;
         host_rdata[VID_PAGE]  = stg_vid[12];
      end
      for (int p = 0; p < NPORTS; p++) begin
         if (host_addr == ADDR_W'(REG_DATA0 + p / PORTS_PER_REG))
            host_rdata[(p % PORTS_PER_REG)*CODE_STRIDE +: CODE_W] = stg_mem[CODE_W*p +: CODE_W];
      end
   end
endmodule

// File: rtl/vlan_cmd_table.sv
module vlan_cmd_table
   import vlan_cmd_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int MEM_W = 16,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   output logic             rd_valid,
   output logic [VID_W-1:0] rd_vid,
   output logic [DB_W-1:0]  rd_db,
   output logic [MEM_W-1:0] rd_mem,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic             wr_valid,
   input  logic [VID_W-1:0] wr_vid,
   input  logic [DB_W-1:0]  wr_db,
   input  logic [MEM_W-1:0] wr_mem,
   output logic [DEPTH-1:0] valid_vec
);
   logic [VID_W-1:0] vid_q [DEPTH];
   logic [DB_W-1:0]  db_q  [DEPTH];
   logic [MEM_W-1:0] mem_q [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) valid_vec <= '0;
      else if (wr_en) valid_vec[wr_idx] <= wr_valid;
   end

   always_ff @(posedge clk) begin
      if (wr_en && wr_valid) begin
         vid_q[wr_idx] <= wr_vid;
         db_q[wr_idx]  <= wr_db;
         mem_q[wr_idx] <= wr_mem;
      end
   end

   assign rd_valid = valid_vec[rd_idx];
   assign rd_vid   = vid_q[rd_idx];
   assign rd_db    = db_q[rd_idx];
   assign rd_mem   = mem_q[rd_idx];
endmodule

// File: rtl/vlan_cmd_seq.sv
module vlan_cmd_seq
   import vlan_cmd_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int MEM_W = 16,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_start,
   input  opc_e             opcode,
   input  logic [VID_W-1:0] stg_vid,
   input  logic             stg_valid,
   input  logic [DB_W-1:0]  stg_db,
   input  logic [MEM_W-1:0] stg_mem,
   output logic [IDX_W-1:0] rd_idx,
   input  logic             rd_valid,
   input  logic [VID_W-1:0] rd_vid,
   input  logic [DB_W-1:0]  rd_db,
   input  logic [MEM_W-1:0] rd_mem,
   output logic             wr_en,
   output logic [IDX_W-1:0] wr_idx,
   output logic             wr_valid,
   output logic [VID_W-1:0] wr_vid,
   output logic [DB_W-1:0]  wr_db,
   output logic [MEM_W-1:0] wr_mem,
   output logic             done,
   output logic             full_set,
   output logic             wb_en,
   output logic [VID_W-1:0] wb_vid,
   output logic             wb_valid,
   output logic [DB_W-1:0]  wb_db,
   output logic [MEM_W-1:0] wb_mem
);
   logic             run_q, found_q, hit_q, free_q;
   logic [IDX_W-1:0] idx_q, hit_idx_q, free_idx_q;
   logic [VID_W-1:0] best_vid_q;
   logic [DB_W-1:0]  best_db_q;
   logic [MEM_W-1:0] best_mem_q;

   logic             cand, slot_hit, slot_free, last;
   logic             n_found, n_hit, n_free;
   logic [IDX_W-1:0] n_hit_idx, n_free_idx;
   logic [VID_W-1:0] n_best_vid;
   logic [DB_W-1:0]  n_best_db;
   logic [MEM_W-1:0] n_best_mem;

   assign rd_idx    = idx_q;
   assign last      = run_q && (idx_q == IDX_W'(DEPTH - 1));
   assign cand      = rd_valid && (rd_vid > stg_vid) && (!found_q || rd_vid < best_vid_q);
   assign slot_hit  = rd_valid && (rd_vid == stg_vid);
   assign slot_free = !rd_valid;

   assign n_found    = found_q | cand;
   assign n_best_vid = cand ? rd_vid : best_vid_q;
   assign n_best_db  = cand ? rd_db  : best_db_q;
   assign n_best_mem = cand ? rd_mem : best_mem_q;
   assign n_hit      = hit_q | slot_hit;
   assign n_hit_idx  = hit_q ? hit_idx_q : idx_q;
   assign n_free     = free_q | slot_free;
   assign n_free_idx = free_q ? free_idx_q : idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q      <= 1'b0;
         idx_q      <= '0;
         found_q    <= 1'b0;
         hit_q      <= 1'b0;
         free_q     <= 1'b0;
         hit_idx_q  <= '0;
         free_idx_q <= '0;
         best_vid_q <= '0;
         best_db_q  <= '0;
         best_mem_q <= '0;
      end else if (cmd_start) begin
         run_q   <= 1'b1;
         idx_q   <= '0;
         found_q <= 1'b0;
         hit_q   <= 1'b0;
         free_q  <= 1'b0;
      end else if (run_q) begin
         found_q    <= n_found;
         best_vid_q <= n_best_vid;
         best_db_q  <= n_best_db;
         best_mem_q <= n_best_mem;
         hit_q      <= n_hit;
         hit_idx_q  <= n_hit_idx;
         free_q     <= n_free;
         free_idx_q <= n_free_idx;
         if (last) run_q <= 1'b0;
         else      idx_q <= idx_q + 1'b1;
      end
   end

   always_comb begin
      wr_en    = 1'b0;
      wr_idx   = idx_q;
      wr_valid = 1'b0;
      full_set = 1'b0;
      if (run_q && opcode == OPC_FLUSH) begin
         wr_en = 1'b1;
      end
      if (last && opcode == OPC_LOAD) begin
         if (n_hit) begin
            wr_en    = 1'b1;
            wr_idx   = n_hit_idx;
            wr_valid = stg_valid;
         end else if (stg_valid && n_free) begin
            wr_en    = 1'b1;
            wr_idx   = n_free_idx;
            wr_valid = 1'b1;
         end else if (stg_valid) begin
            full_set = 1'b1;
         end
      end
   end

   assign wr_vid   = stg_vid;
   assign wr_db    = stg_db;
   assign wr_mem   = stg_mem;
   assign done     = last;
   assign wb_en    = last && (opcode == OPC_NEXT);
   assign wb_valid = n_found;
   assign wb_vid   = n_found ? n_best_vid : '1;
   assign wb_db    = n_found ? n_best_db  : stg_db;
   assign wb_mem   = n_found ? n_best_mem : stg_mem;
endmodule

// File: rtl/vlan_cmd_engine.sv
module vlan_cmd_engine
   import vlan_cmd_pkg::*;
#(
   parameter int DEPTH  = 16,
   parameter int NPORTS = 8,
   parameter int ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_we,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [REG_W-1:0]  host_wdata,
   output logic [REG_W-1:0]  host_rdata
);
   localparam int MEM_W = CODE_W * NPORTS;
   localparam int IDX_W = $clog2(DEPTH);
   localparam int NDREG = (NPORTS + PORTS_PER_REG - 1) / PORTS_PER_REG;

   if (DEPTH < 2) begin : g_bad_depth
      $error("vlan_cmd_engine: DEPTH must be at least 2");
   end
   if (NPORTS < 1) begin : g_bad_ports
      $error("vlan_cmd_engine: NPORTS must be at least 1");
   end
   if (REG_DATA0 + NDREG > (1 << ADDR_W)) begin : g_bad_addr
      $error("vlan_cmd_engine: ADDR_W too small for the data registers");
   end

   logic             start_w, busy_w, stg_valid_w, full_w, done_w, full_set_w;
   opc_e             opc_w;
   logic [VID_W-1:0] stg_vid_w, wb_vid_w, rd_vid_w, wr_vid_w;
   logic [DB_W-1:0]  stg_db_w, wb_db_w, rd_db_w, wr_db_w;
   logic [MEM_W-1:0] stg_mem_w, wb_mem_w, rd_mem_w, wr_mem_w;
   logic             wb_en_w, wb_valid_w, rd_valid_w, wr_en_w, wr_valid_w;
   logic [IDX_W-1:0] rd_idx_w, wr_idx_w;
   logic [DEPTH-1:0] valid_vec_w;

   vlan_cmd_regs #(.NPORTS(NPORTS), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .cmd_start(start_w), .busy(busy_w), .opcode(opc_w),
      .stg_vid(stg_vid_w), .stg_valid(stg_valid_w), .stg_db(stg_db_w), .stg_mem(stg_mem_w),
      .full(full_w), .eng_done(done_w), .full_set(full_set_w),
      .wb_en(wb_en_w), .wb_vid(wb_vid_w), .wb_valid(wb_valid_w), .wb_db(wb_db_w), .wb_mem(wb_mem_w)
   );

   vlan_cmd_seq #(.DEPTH(DEPTH), .MEM_W(MEM_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .cmd_start(start_w), .opcode(opc_w),
      .stg_vid(stg_vid_w), .stg_valid(stg_valid_w), .stg_db(stg_db_w), .stg_mem(stg_mem_w),
      .rd_idx(rd_idx_w), .rd_valid(rd_valid_w), .rd_vid(rd_vid_w), .rd_db(rd_db_w), .rd_mem(rd_mem_w),
      .wr_en(wr_en_w), .wr_idx(wr_idx_w), .wr_valid(wr_valid_w),
      .wr_vid(wr_vid_w), .wr_db(wr_db_w), .wr_mem(wr_mem_w),
      .done(done_w), .full_set(full_set_w),
      .wb_en(wb_en_w), .wb_vid(wb_vid_w), .wb_valid(wb_valid_w), .wb_db(wb_db_w), .wb_mem(wb_mem_w)
   );

   vlan_cmd_table #(.DEPTH(DEPTH), .MEM_W(MEM_W)) u_table (
      .clk(clk), .rst_n(rst_n),
      .rd_idx(rd_idx_w), .rd_valid(rd_valid_w), .rd_vid(rd_vid_w), .rd_db(rd_db_w), .rd_mem(rd_mem_w),
      .wr_en(wr_en_w), .wr_idx(wr_idx_w), .wr_valid(wr_valid_w),
      .wr_vid(wr_vid_w), .wr_db(wr_db_w), .wr_mem(wr_mem_w),
      .valid_vec(valid_vec_w)
   );
endmodule

// File: rtl/vlan_cmd_chk.sv
module vlan_cmd_chk
   import vlan_cmd_pkg::*;
#(
   parameter int DEPTH = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             busy,
   input logic             done,
   input opc_e             opcode,
   input logic [VID_W-1:0] stg_vid,
   input logic             full,
   input logic [DEPTH-1:0] valid_vec,
   input logic             wb_en,
   input logic             wb_valid,
   input logic [VID_W-1:0] wb_vid
);
   localparam int CNT_W = $clog2(DEPTH + 2) + 1;
   logic [CNT_W-1:0] busy_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         busy_cnt <= '0;
      else if (!busy)                     busy_cnt <= '0;
      else if (busy_cnt <= CNT_W'(DEPTH)) busy_cnt <= busy_cnt + 1'b1;
   end

   AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      busy_cnt <= CNT_W'(DEPTH)); // R1

   AST_STAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !done |=> $stable(stg_vid)); // R2

   AST_NEXT_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
      done && wb_en && wb_valid |-> wb_vid > stg_vid); // R3

   AST_FULL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(full) |-> $past(done) && opcode == OPC_LOAD); // R7

   AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) && opcode == OPC_FLUSH |-> valid_vec == '0); // R8
endmodule

bind vlan_cmd_engine vlan_cmd_chk #(.DEPTH(DEPTH)) u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy_w), .done(done_w), .opcode(opc_w),
   .stg_vid(stg_vid_w), .full(full_w), .valid_vec(valid_vec_w),
   .wb_en(wb_en_w), .wb_valid(wb_valid_w), .wb_vid(wb_vid_w)
);

// File: tb/sim_vlan_cmd_engine.sv
module sim_vlan_cmd_engine;
   localparam int D  = 16;
   localparam int NP = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        we = 1'b0;
   logic [3:0]  addr = 4'd0;
   logic [15:0] wdata = 16'd0;
   logic [15:0] rdata;

   int checks = 0;
   int fails  = 0;

   logic [12:0] mv   [D];
   logic [7:0]  mdb  [D];
   logic [15:0] mm   [D];
   bit          mval [D];

   vlan_cmd_engine #(.DEPTH(D), .NPORTS(NP), .ADDR_W(4)) u0 (
      .clk(clk), .rst_n(rst_n), .host_we(we), .host_addr(addr),
      .host_wdata(wdata), .host_rdata(rdata)
   );

   always #2 clk = ~clk;

   initial begin
      #(4 * 150000);
      fails++;
      $display("FAIL watchdog: run did not finish actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic rd(input logic [3:0] a, output logic [15:0] d);
      addr = a;
      #1;
      d = rdata;
   endtask

   task automatic wr(input logic [3:0] a, input logic [15:0] d);
      @(negedge clk);
      we = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      we = 1'b0;
   endtask

   function automatic logic [15:0] pack(input logic [15:0] mem, input int k);
      logic [15:0] r = 16'd0;
      for (int j = 0; j < 4; j++) r[j*4 +: 2] = mem[2*(4*k + j) +: 2];
      return r;
   endfunction

   task automatic start(input logic [2:0] opc, input logic [7:0] db);
      wr(4'd0, {1'b1, opc, db[7:4], 4'b0000, db[3:0]});
   endtask

   task automatic wait_idle(output int n);
      logic [15:0] r;
      n = 0;
      rd(4'd0, r);
      while (r[15]) begin
         n++;
         @(negedge clk);
         rd(4'd0, r);
      end
   endtask

   task automatic stage(input logic [12:0] vid, input logic valid, input logic [15:0] mem);
      wr(4'd1, {2'b00, vid[12], valid, vid[11:0]});
      wr(4'd2, pack(mem, 0));
      wr(4'd3, pack(mem, 1));
   endtask

   task automatic exp_next(input logic [12:0] thr, output bit found, output int bi);
      found = 0; bi = 0;
      for (int s = 0; s < D; s++)
         if (mval[s] && mv[s] > thr && (!found || mv[s] < mv[bi])) begin
            found = 1; bi = s;
         end
   endtask

   task automatic do_load(input string req, input logic [12:0] vid, input logic [7:0] db,
                          input logic [15:0] mem);
      int n, hit, fr;
      bit efull;
      logic [15:0] r;
      hit = -1; fr = -1;
      for (int s = 0; s < D; s++) begin
         if (mval[s] && mv[s] == vid && hit < 0) hit = s;
         if (!mval[s] && fr < 0) fr = s;
      end
      efull = 0;
      if (hit >= 0) begin mdb[hit] = db; mm[hit] = mem; end
      else if (fr >= 0) begin mval[fr] = 1; mv[fr] = vid; mdb[fr] = db; mm[fr] = mem; end
      else efull = 1;
      stage(vid, 1'b1, mem);
      start(3'd3, db);
      wait_idle(n);
      rd(4'd0, r);
      chk({req, " R7 full flag"}, {31'd0, r[4]}, {31'd0, efull});
   endtask

   task automatic do_purge(input logic [12:0] vid);
      int n;
      for (int s = 0; s < D; s++) if (mval[s] && mv[s] == vid) mval[s] = 0;
      stage(vid, 1'b0, 16'd0);
      start(3'd3, 8'd0);
      wait_idle(n);
   endtask

   task automatic walk(input string req, input logic [12:0] from);
      logic [12:0] thr;
      logic [15:0] r;
      bit found;
      int bi, n;
      thr = from;
      stage(from, 1'b0, 16'd0);
      for (int step = 0; step < D + 2; step++) begin
         start(3'd4, 8'd0);
         wait_idle(n);
         chk({req, " R1 busy cycles"}, n, D);
         exp_next(thr, found, bi);
         rd(4'd1, r);
         if (found) begin
            chk({req, " R3 vid"}, {16'd0, r}, {16'd0, 2'b00, mv[bi][12], 1'b1, mv[bi][11:0]});
            rd(4'd0, r);
            chk({req, " R9 db nibbles"}, {24'd0, r[11:8], r[3:0]}, {24'd0, mdb[bi]});
            rd(4'd2, r);
            chk({req, " R9 data0"}, {16'd0, r}, {16'd0, pack(mm[bi], 0)});
            rd(4'd3, r);
            chk({req, " R9 data1"}, {16'd0, r}, {16'd0, pack(mm[bi], 1)});
            thr = mv[bi];
         end else begin
            chk({req, " R4 end marker"}, {16'd0, r}, 32'h2FFF);
            break;
         end
      end
   endtask

   function automatic logic [15:0] mk_mem(input int k);
      logic [15:0] m = 16'd0;
      for (int p = 0; p < NP; p++) m[2*p +: 2] = 2'((k + 3*p) & 3);
      return m;
   endfunction

   function automatic logic [12:0] mk_vid(input int k);
      return 13'((k * 509 + 37) % 8192);
   endfunction

   initial begin
      logic [15:0] r;
      int n;
      for (int s = 0; s < D; s++) begin mval[s] = 0; mv[s] = 0; mdb[s] = 0; mm[s] = 0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      rd(4'd0, r); chk("R10 op reg after reset", {16'd0, r}, 32'd0);
      rd(4'd1, r); chk("R10 vid reg after reset", {16'd0, r}, 32'd0);
      rd(4'd2, r); chk("R10 data reg after reset", {16'd0, r}, 32'd0);
      walk("R10 empty table", 13'd0);

      for (int k = 0; k < D; k++)
         do_load("R5 fill", mk_vid(k), 8'((k * 37 + 5) & 255), mk_mem(k));
      walk("R3 full walk", 13'd0);
      walk("R3 walk from present vid", mk_vid(4));

      do_load("R7 new vid into full table", 13'd100, 8'h77, 16'hFFFF);
      walk("R7 table unchanged", 13'd0);

      do_load("R5 overwrite while full", mk_vid(3), 8'hA5, 16'h1B1B);
      walk("R5 after overwrite", 13'd0);

      do_purge(mk_vid(5));
      walk("R6 after purge", 13'd0);
      do_purge(13'd7);
      walk("R6 purge of absent vid", 13'd0);

      do_load("R5 top vid", 13'd8191, 8'h3C, 16'h9999);
      walk("R3 walk across top vid", 13'd8000);
      do_load("R7 full again", 13'd100, 8'h77, 16'hFFFF);
      do_purge(mk_vid(9));
      do_load("R5 load into freed slot", 13'd100, 8'h77, 16'hC3C3);
      walk("R5 walk after reload", 13'd0);

      stage(13'd0, 1'b0, 16'd0);
      start(3'd4, 8'd0);
      wr(4'd1, 16'h1005);
      wr(4'd2, 16'hFFFF);
      wr(4'd0, 16'h9F0F);
      wait_idle(n);
      begin
         bit found; int bi;
         exp_next(13'd0, found, bi);
         rd(4'd1, r);
         chk("R2 vid after writes during busy", {16'd0, r},
             {16'd0, 2'b00, mv[bi][12], 1'b1, mv[bi][11:0]});
         rd(4'd2, r);
         chk("R2 data0 after writes during busy", {16'd0, r}, {16'd0, pack(mm[bi], 0)});
         rd(4'd0, r);
         chk("R2 db after writes during busy", {24'd0, r[11:8], r[3:0]}, {24'd0, mdb[bi]});
         chk("R2 busy clear", {31'd0, r[15]}, 32'd0);
      end

      start(3'd1, 8'd0);
      wait_idle(n);
      chk("R8 R1 flush busy cycles", n, D);
      for (int s = 0; s < D; s++) mval[s] = 0;
      walk("R8 after flush", 13'd0);
      do_load("R8 load after flush", 13'd4097, 8'h12, 16'h0F0F);
      walk("R8 walk after flush and load", 13'd0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule